// File: doc/BRIEF.md
# Fault Auto-Retry Restart Timer

This block supervises an output power stage. When the stage reports a fault, the block holds the stage in reset and withdraws the PWM enable, so all switching stops. It then counts out a hold-off interval and lets the stage go, which gives the stage a chance to come back up by itself. The interval is picked by a 4-bit code kept in a single configuration register.

The configuration register sits behind a plain write port with address, data and a write enable. After each reset it accepts exactly one valid code. A write that carries an unused code is dropped and leaves that single write available. The current code and a "write used" flag can be read back at any time. Time is counted in ticks of 0.1 ms. A parameter sets how many clock cycles make one tick, and a second parameter sets how many ticks make one step of about 149.6 ms. Both can be scaled down for simulation. All pins are plain control and status signals. There is no streamed data, so no valid/ready handshake is needed.

Top module: `fault_retry_timer`

## Requirements
- R1: After reset, stage_rst=0, pwm_en=1, busy=0, rd_code=2 and rd_locked=0.
- R2: On the first rising clock edge at which fault_in is sampled high, stage_rst becomes 1, pwm_en becomes 0 and busy becomes 1.
- R3: For a code c from 2 to 10, the stage is released (stage_rst goes to 0, pwm_en to 1 and busy to 0) exactly c*STEP_TICKS*CYC_PER_TICK clock cycles after the last edge that sampled fault_in high.
- R4: Code 11 gives the same hold-off as code 10, which is the longest interval.
- R5: The codes 0, 1 and 12 to 15 are reserved. A write that carries one of them leaves both rd_code and rd_locked unchanged.
- R6: After one valid write has been accepted, every later write is ignored until the next reset.
- R7: A write is accepted only when wr_addr equals REG_ADDR. A write to any other address has no effect.
- R8: A fault that arrives during the hold-off starts the wait again from zero.
- R9: pwm_en is always the inverse of stage_rst, and busy always equals stage_rst.
- R10: The code is taken from wr_data[3:0] and the higher data bits are ignored. An accepted write shows up on rd_code, with rd_locked=1, from the next clock edge.
- R11: The hold-off uses the code that is in force on the edge that captures the fault. Before any write, that is the default code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_in | input | 1 | Fault indication from the power stage |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Configuration write address |
| wr_data | input | DATA_W | Configuration write data; the code is in bits [3:0] |
| stage_rst | output | 1 | Holds the power stage in reset |
| pwm_en | output | 1 | Enables PWM activity |
| busy | output | 1 | Hold-off in progress |
| rd_code | output | 4 | Current period code |
| rd_locked | output | 1 | The single permitted write has been used |

## Verification
Every one of the 16 code values is written after a fresh reset and then timed with a single fault pulse. This shows that the ten valid codes are accepted with the correct interval, that code 11 gives the same interval as code 10, and that the six reserved codes are turned away while the default interval stays in force. Further patterns test the rules of the write port:
- a valid write after a reserved one;
- a second valid write;
- a write to the wrong address;
- data with the high bits set.

These patterns separate three cases: write rejected, write taken, and lock used up. Finally, a second fault during the hold-off and a fault held high for several cycles show that the wait is measured from the last fault edge.

// File: rtl/fault_retry_pkg.sv
package fault_retry_pkg;
  localparam int CODE_W      = 4;
  localparam int DEFAULT_CODE = 2;
  localparam int MAX_MULT    = 10;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c >= 4'd2) && (c <= 4'd11);
  endfunction

  function automatic int unsigned code_mult(input logic [CODE_W-1:0] c);
    if (c == 4'd11) return MAX_MULT;
    else if (code_ok(c)) return int'(c);
    else return DEFAULT_CODE;
  endfunction
endpackage

// File: rtl/retry_cfg_reg.sv
module retry_cfg_reg
  import fault_retry_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] code,
  output logic              locked
);
  logic [CODE_W-1:0] new_code;
  logic              take;

  assign new_code = wr_data[CODE_W-1:0];
  assign take     = wr_en && (wr_addr == ADDR_W'(REG_ADDR)) && !locked && code_ok(new_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code   <= CODE_W'(DEFAULT_CODE);
      locked <= 1'b0;
    end else if (take) begin
      code   <= new_code;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/retry_tick_gen.sv
module retry_tick_gen #(
  parameter int CYC_PER_TICK = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  logic [CW-1:0] cnt_q;

  generate
    if (CYC_PER_TICK == 1) begin : g_every
      assign tick = en;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= '0;
      end
    end else begin : g_div
      assign tick = en && (cnt_q == CW'(CYC_PER_TICK - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/retry_holdoff_ctrl.sv
module retry_holdoff_ctrl
  import fault_retry_pkg::*;
#(
  parameter int STEP_TICKS = 1496
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              hold
);
  localparam int TW = $clog2(MAX_MULT * STEP_TICKS + 1);
  logic [TW-1:0] tgt_q, tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= 1'b0;
      tcnt_q <= '0;
      tgt_q  <= TW'(DEFAULT_CODE * STEP_TICKS);
    end else if (fault) begin
      hold   <= 1'b1;
      tcnt_q <= '0;
      tgt_q  <= TW'(code_mult(code) * STEP_TICKS);
    end else if (hold && tick) begin
      if (tcnt_q == tgt_q - 1'b1) begin
        hold   <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_retry_timer.sv
module fault_retry_timer
  import fault_retry_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int REG_ADDR     = 12,
  parameter int CYC_PER_TICK = 5000,
  parameter int STEP_TICKS   = 1496
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              stage_rst,
  output logic              pwm_en,
  output logic              busy,
  output logic [3:0]        rd_code,
  output logic              rd_locked
);
  logic [CODE_W-1:0] code;
  logic              locked, hold, tick;

  retry_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .code(code), .locked(locked)
  );

  retry_tick_gen #(.CYC_PER_TICK(CYC_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(fault_in || !hold), .en(hold), .tick(tick)
  );

  retry_holdoff_ctrl #(.STEP_TICKS(STEP_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .fault(fault_in), .tick(tick), .code(code), .hold(hold)
  );

  assign stage_rst = hold;
  assign pwm_en    = !hold;
  assign busy      = hold;
  assign rd_code   = code;
  assign rd_locked = locked;
endmodule

// File: rtl/fault_retry_timer_chk.sv
module fault_retry_timer_chk
  import fault_retry_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int REG_ADDR     = 12,
  parameter int CYC_PER_TICK = 5000,
  parameter int STEP_TICKS   = 1496
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_in,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              stage_rst,
  input logic              pwm_en,
  input logic              busy,
  input logic [3:0]        rd_code,
  input logic              rd_locked
);
  int unsigned held_q, want_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 0;
      want_q <= 0;
    end else if (fault_in) begin
      held_q <= 1;
      want_q <= code_mult(rd_code) * STEP_TICKS * CYC_PER_TICK;
    end else if (stage_rst) begin
      held_q <= held_q + 1;
    end
  end

  assert_fault_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> (stage_rst && !pwm_en && busy));

  assert_release_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stage_rst) |-> (held_q == want_q + 1));

  assert_code_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(rd_code));

  assert_reserved_no_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !code_ok(wr_data[3:0])) |=> ($stable(rd_locked) && $stable(rd_code)));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_locked |=> (rd_locked && $stable(rd_code)));

  assert_wrong_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_W'(REG_ADDR)) |=> ($stable(rd_locked) && $stable(rd_code)));

  assert_outputs_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en == !stage_rst) && (busy == stage_rst));
endmodule

bind fault_retry_timer fault_retry_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
  .CYC_PER_TICK(CYC_PER_TICK), .STEP_TICKS(STEP_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .stage_rst(stage_rst),
  .pwm_en(pwm_en), .busy(busy), .rd_code(rd_code), .rd_locked(rd_locked)
);

// File: tb/fault_retry_timer_tb.sv
module fault_retry_timer_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int RADDR  = 12;
  localparam int CYC    = 3;
  localparam int STEP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_in = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic stage_rst, pwm_en, busy, rd_locked;
  logic [3:0] rd_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fault_retry_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(RADDR),
                      .CYC_PER_TICK(CYC), .STEP_TICKS(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .stage_rst(stage_rst),
    .pwm_en(pwm_en), .busy(busy), .rd_code(rd_code), .rd_locked(rd_locked)
  );

  function automatic bit valid_code(input int c);
    return (c >= 2) && (c <= 11);
  endfunction

  function automatic int hold_cycles(input int c);
    int m;
    m = (c == 11) ? 10 : c;
    return m * STEP * CYC;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fault_in = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_reg(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_fault(input int len);
    @(negedge clk);
    fault_in = 1'b1;
    repeat (len) @(negedge clk);
    fault_in = 1'b0;
  endtask

  // Counts the cycles from the last fault-capturing edge until release.
  task automatic time_release(output int n, output bit agree);
    n = 0;
    agree = 1'b1;
    while (stage_rst && n < 1000) begin
      @(negedge clk);
      n++;
      if ((pwm_en != !stage_rst) || (busy != stage_rst)) agree = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    bit agree;

    do_reset();
    // R1 reset state
    check(stage_rst == 1'b0 && pwm_en == 1'b1 && busy == 1'b0, "R1 reset outputs",
          {stage_rst, pwm_en, busy}, 3'b010);
    check(rd_code == 4'd2 && rd_locked == 1'b0, "R1 reset readback",
          {rd_locked, rd_code}, 5'h02);

    // R11 default period before any write
    pulse_fault(1);
    check(stage_rst && !pwm_en && busy, "R2 fault capture", {stage_rst, pwm_en, busy}, 3'b101);
    time_release(n, agree);
    check(n == hold_cycles(2), "R11 default hold", n, hold_cycles(2));
    check(agree, "R9 output agreement", agree, 1);

    // Full sweep of all codes: R3 R4 R5 R10
    for (int c = 0; c < 16; c++) begin
      do_reset();
      write_reg(RADDR, c);
      check(rd_locked == valid_code(c), "R5 R10 lock after write", rd_locked, valid_code(c));
      check(rd_code == (valid_code(c) ? c : 2), "R5 R10 code after write", rd_code,
            valid_code(c) ? c : 2);
      pulse_fault(1);
      check(stage_rst && !pwm_en && busy, "R2 fault capture", {stage_rst, pwm_en, busy}, 3'b101);
      time_release(n, agree);
      check(n == hold_cycles(valid_code(c) ? c : 2), c == 11 ? "R4 code 11 hold" : "R3 hold",
            n, hold_cycles(valid_code(c) ? c : 2));
      check(agree && !stage_rst && pwm_en && !busy, "R9 release state", agree, 1);
    end

    // R5 reserved write does not use the single write, then R6 lock
    do_reset();
    write_reg(RADDR, 13);
    check(!rd_locked && rd_code == 4'd2, "R5 reserved rejected", {rd_locked, rd_code}, 5'h02);
    write_reg(RADDR, 7);
    check(rd_locked && rd_code == 4'd7, "R5 valid after reserved", {rd_locked, rd_code}, 5'h17);
    write_reg(RADDR, 4);
    check(rd_locked && rd_code == 4'd7, "R6 second write ignored", rd_code, 7);
    pulse_fault(1);
    time_release(n, agree);
    check(n == hold_cycles(7), "R6 hold keeps first code", n, hold_cycles(7));

    // R7 wrong address
    do_reset();
    write_reg(RADDR + 1, 9);
    check(!rd_locked && rd_code == 4'd2, "R7 wrong address ignored", {rd_locked, rd_code}, 5'h02);

    // R10 upper data bits ignored
    write_reg(RADDR, 8'hF5);
    check(rd_locked && rd_code == 4'd5, "R10 low nibble taken", rd_code, 5);

    // R8 restart of wait on new fault during hold-off
    pulse_fault(1);
    repeat (7) @(negedge clk);
    check(stage_rst, "R8 still holding", stage_rst, 1);
    pulse_fault(1);
    time_release(n, agree);
    check(n == hold_cycles(5), "R8 wait restarted", n, hold_cycles(5));

    // R8 fault held for several cycles: wait counts from last sampled edge
    pulse_fault(6);
    time_release(n, agree);
    check(n == hold_cycles(5), "R8 long fault", n, hold_cycles(5));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule